// File: doc/BRIEF.md
# Instruction Cracker with Microcode Sequencer

The cracker sits between the decode positions of a front end and the dispatch stage. It takes a group of up to four pre-decoded instruction descriptors and turns each one into simple load, ALU and store micro-ops. It hands dispatch up to four micro-ops per cycle, packed into lanes starting at lane 0. Short instructions are expanded by fixed logic. An instruction's addressing form sets whether it yields one, two or three micro-ops. A group of lanes can hold several instructions, or it can split one instruction across two groups.

Instructions flagged as complex always need more than three micro-ops. They go to a microcode sequencer. The sequencer reads a built-in ROM routine and emits four micro-ops per cycle until the routine's end marker, then hands back to the fixed expansion. Every micro-op carries an end-of-instruction flag so that retirement can find the boundaries of the original instructions. A valid/ready pair on each side throttles the descriptor supply and the dispatch stage.

Descriptor (16 bits per slot, slot 0 in the least significant bits of `inDesc`): class [15:13], form [12:11], complex [10], routine [9:8], dst [7:4], src [3:0]. Micro-op (14 bits per lane, lane 0 in the least significant bits of `outUop`): kind [13:12] (0 = ALU, 1 = LOAD, 2 = STORE), class [11:9], dst [8:5], src [4:1], end-of-instruction [0]. Register 15 is the scratch temporary.

Top module: `crk_cracker`

## Requirements
- R1: A non-complex descriptor with form 0 or form 3 yields one ALU micro-op carrying the descriptor's class, dst and src.
- R2: Form 1 (memory source) yields two micro-ops: LOAD with dst=15 and src=descriptor src, then ALU with dst=descriptor dst and src=15.
- R3: Form 2 (memory destination) yields three micro-ops: LOAD with dst=15 and src=descriptor dst, then ALU with dst=15 and src=descriptor src, then STORE with dst=descriptor dst and src=15.
- R4: A complex descriptor with routine r runs a microcode routine of 4+2r micro-ops. Step j is a STORE when it is the final step, a LOAD when j is even, and an ALU op otherwise. dst is the descriptor dst. src is the descriptor src for a LOAD and 15 for the other kinds. Class is copied from the descriptor.
- R5: A complex instruction always starts in lane 0 of a fresh group. Its groups are full (four lanes) except the one that holds its final micro-op.
- R6: Outside microcode, each group is filled greedily in program order with up to four micro-ops. Filling stops only at the end of the held descriptors or at a complex descriptor. An instruction may therefore be split across groups.
- R7: The end-of-instruction bit is 1 on exactly the last micro-op of each instruction and 0 on all others.
- R8: While the microcode sequencer is driving the output, inReady is 0.
- R9: While outValid is 1 and outReady is 0, outValid stays 1 and outUop and outLaneValid stay unchanged.
- R10: During and right after reset, outValid is 0, outLaneValid is 0 and inReady is 1.
- R11: Only slots below inCount are expanded. A group accepted with inCount 0 produces no output.
- R12: In the cycle that the last group of a held set is taken by dispatch, and that group is not microcode, inReady is 1, so a new set is accepted with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Descriptor set offered |
| inReady | output | 1 | Cracker can take a descriptor set |
| inCount | input | 3 | Number of valid slots, from 0 to 4 |
| inDesc | input | 64 | Four 16-bit descriptors |
| outValid | output | 1 | Micro-op group offered to dispatch |
| outReady | input | 1 | Dispatch takes the group |
| outLaneValid | output | 4 | Lane occupancy, packed from lane 0 |
| outUop | output | 56 | Four 14-bit micro-ops |

## Verification
A descriptor set is accepted on a rising edge. Its first group appears combinationally from the held set in the next cycle. Each later group follows the edge on which dispatch took the one before it. The bench therefore compares lanes only on falling edges where outValid and outReady are both 1, popping expected micro-ops from a scoreboard in program order. This makes stalls invisible to the comparison and leaves only packing and content to check. Hold-on-stall is checked one falling edge after a stalled sample. Zero-bubble acceptance is checked as exactly one clock period between two acceptance edges.

// File: rtl/crk_pkg.sv
package crk_pkg;
  localparam int SLOTS  = 4;
  localparam int LANES  = 4;
  localparam int REG_W  = 4;
  localparam int OP_W   = 3;
  localparam int RT_W   = 2;
  localparam int STEP_W = 4;
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int IDX_W  = $clog2(SLOTS);
  localparam logic [REG_W-1:0] TMP_REG = '1;

  typedef enum logic [1:0] {K_ALU = 2'd0, K_LOAD = 2'd1, K_STORE = 2'd2} uopKind_e;

  typedef struct packed {
    logic [OP_W-1:0]  opClass;
    logic [1:0]       form;
    logic             cplx;
    logic [RT_W-1:0]  routine;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
  } instDesc_t;

  typedef struct packed {
    uopKind_e         kind;
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
    logic             eoi;
  } uop_t;

  typedef struct packed {
    logic     valid;
    uopKind_e kind;
    logic     srcTmp;
    logic     last;
  } ucWord_t;

  typedef struct packed {
    logic load;
    logic advance;
  } ctlStrobe_t;

  typedef struct packed {
    logic seqActive;
    logic lastGroup;
  } dpStatus_t;

  localparam int DESC_W = $bits(instDesc_t);
  localparam int UOP_W  = $bits(uop_t);
endpackage

// File: rtl/crk_ucode_rom.sv
module crk_ucode_rom
  import crk_pkg::*;
#(
  parameter int PORTS = 4
) (
  input  logic [RT_W-1:0]              routine,
  input  logic [PORTS-1:0][STEP_W-1:0] step,
  output ucWord_t [PORTS-1:0]          word
);
  localparam int DEPTH = 2 ** (RT_W + STEP_W);

  function automatic ucWord_t mkWord(input int r, input int j);
    ucWord_t w;
    int len;
    len = 4 + 2 * r;
    w = '0;
    if (j < len) begin
      w.valid = 1'b1;
      w.last  = (j == len - 1);
      if (j == len - 1) begin
        w.kind = K_STORE; w.srcTmp = 1'b1;
      end else if (j % 2 == 0) begin
        w.kind = K_LOAD;  w.srcTmp = 1'b0;
      end else begin
        w.kind = K_ALU;   w.srcTmp = 1'b1;
      end
    end
    return w;
  endfunction

  ucWord_t romArr [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign romArr[a] = mkWord(a / (2 ** STEP_W), a % (2 ** STEP_W));
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign word[p] = romArr[{routine, step[p]}];
  end
endmodule

// File: rtl/crk_datapath.sv
module crk_datapath
  import crk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctlStrobe_t              strobe,
  input  logic [CNT_W-1:0]        inCount,
  input  instDesc_t [SLOTS-1:0]   inDesc,
  output uop_t [LANES-1:0]        laneUop,
  output logic [LANES-1:0]        laneValid,
  output dpStatus_t               status
);
  instDesc_t [SLOTS-1:0] hold;
  logic [CNT_W-1:0]  cnt, cur, nextCur, s;
  logic [STEP_W-1:0] sub, nextSub;
  logic [1:0]        k, n;
  logic              stop, anyLast, seqActive;
  instDesc_t         curDesc, d;
  logic [LANES-1:0][STEP_W-1:0] romStep;
  ucWord_t [LANES-1:0]          romWord;

  function automatic logic [1:0] uopCount(input logic [1:0] form);
    case (form)
      2'd1:    return 2'd2;
      2'd2:    return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  function automatic uop_t fastUop(input instDesc_t di, input logic [1:0] kk);
    uop_t u;
    u = '0;
    u.op = di.opClass;
    case (di.form)
      2'd1: begin
        if (kk == 2'd0) begin u.kind = K_LOAD; u.dst = TMP_REG; u.src = di.src; end
        else            begin u.kind = K_ALU;  u.dst = di.dst;  u.src = TMP_REG; end
      end
      2'd2: begin
        if (kk == 2'd0)      begin u.kind = K_LOAD;  u.dst = TMP_REG; u.src = di.dst;  end
        else if (kk == 2'd1) begin u.kind = K_ALU;   u.dst = TMP_REG; u.src = di.src;  end
        else                 begin u.kind = K_STORE; u.dst = di.dst;  u.src = TMP_REG; end
      end
      default: begin u.kind = K_ALU; u.dst = di.dst; u.src = di.src; end
    endcase
    return u;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      cnt  <= '0;
      cur  <= '0;
      sub  <= '0;
    end else if (strobe.load) begin
      hold <= inDesc;
      cnt  <= inCount;
      cur  <= '0;
      sub  <= '0;
    end else if (strobe.advance) begin
      cur  <= nextCur;
      sub  <= nextSub;
    end
  end

  assign curDesc   = (cur < cnt) ? hold[cur[IDX_W-1:0]] : '0;
  assign seqActive = (cur < cnt) && curDesc.cplx;

  always_comb begin
    for (int l = 0; l < LANES; l++) romStep[l] = sub + STEP_W'(l);
  end

  crk_ucode_rom #(.PORTS(LANES)) u_rom (
    .routine (curDesc.routine),
    .step    (romStep),
    .word    (romWord)
  );

  always_comb begin
    laneUop   = '0;
    laneValid = '0;
    s         = cur;
    k         = sub[1:0];
    stop      = 1'b0;
    anyLast   = 1'b0;
    d         = '0;
    n         = 2'd1;
    nextCur   = cur;
    nextSub   = sub;
    if (seqActive) begin
      for (int l = 0; l < LANES; l++) begin
        if (romWord[l].valid) begin
          laneValid[l]    = 1'b1;
          laneUop[l].kind = romWord[l].kind;
          laneUop[l].op   = curDesc.opClass;
          laneUop[l].dst  = curDesc.dst;
          laneUop[l].src  = romWord[l].srcTmp ? TMP_REG : curDesc.src;
          laneUop[l].eoi  = romWord[l].last;
          if (romWord[l].last) anyLast = 1'b1;
        end
      end
      if (anyLast) begin
        nextCur = cur + CNT_W'(1);
        nextSub = '0;
      end else begin
        nextSub = sub + STEP_W'(LANES);
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        d = hold[s[IDX_W-1:0]];
        if (!stop && (s < cnt) && !d.cplx) begin
          n              = uopCount(d.form);
          laneValid[l]   = 1'b1;
          laneUop[l]     = fastUop(d, k);
          laneUop[l].eoi = (k == n - 2'd1);
          if (k == n - 2'd1) begin
            s = s + CNT_W'(1);
            k = 2'd0;
          end else begin
            k = k + 2'd1;
          end
        end else begin
          stop = 1'b1;
        end
      end
      nextCur = s;
      nextSub = STEP_W'(k);
    end
  end

  assign status.seqActive = seqActive;
  assign status.lastGroup = (nextCur >= cnt);
endmodule

// File: rtl/crk_control.sv
module crk_control
  import crk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [CNT_W-1:0] inCount,
  input  logic             outReady,
  input  dpStatus_t        status,
  output logic             inReady,
  output logic             outValid,
  output ctlStrobe_t       strobe
);
  logic bufValid, fire;

  assign outValid = bufValid;
  assign fire     = bufValid && outReady;
  assign inReady  = !bufValid || (fire && status.lastGroup && !status.seqActive);

  assign strobe.load    = inValid && inReady;
  assign strobe.advance = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         bufValid <= 1'b0;
    else if (strobe.load)               bufValid <= (inCount != '0);
    else if (fire && status.lastGroup)  bufValid <= 1'b0;
  end
endmodule

// File: rtl/crk_cracker.sv
module crk_cracker
  import crk_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [CNT_W-1:0]         inCount,
  input  logic [SLOTS*DESC_W-1:0]  inDesc,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [LANES-1:0]         outLaneValid,
  output logic [LANES*UOP_W-1:0]   outUop
);
  ctlStrobe_t            strobe;
  dpStatus_t             status;
  instDesc_t [SLOTS-1:0] descArr;
  uop_t [LANES-1:0]      laneUop;
  logic                  seqActive;

  assign descArr   = inDesc;
  assign outUop    = laneUop;
  assign seqActive = status.seqActive;

  crk_control u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inCount  (inCount),
    .outReady (outReady),
    .status   (status),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  crk_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .inCount   (inCount),
    .inDesc    (descArr),
    .laneUop   (laneUop),
    .laneValid (outLaneValid),
    .status    (status)
  );
endmodule

// File: rtl/crk_checker.sv
module crk_checker
  import crk_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   inReady,
  input logic                   outValid,
  input logic                   outReady,
  input logic [LANES-1:0]       outLaneValid,
  input logic [LANES*UOP_W-1:0] outUop,
  input logic                   seqActive
);
  logic [LANES-1:0] eoiBits;
  always_comb begin
    for (int l = 0; l < LANES; l++) eoiBits[l] = outUop[l*UOP_W];
  end

  AST_SEQ_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    seqActive |-> !inReady); // R8
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outUop) && $stable(outLaneValid))); // R9
  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outLaneValid[0] && ((outLaneValid & (outLaneValid + 1'b1)) == '0))); // R6
  AST_SEQ_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && seqActive && (eoiBits == '0)) |-> (&outLaneValid)); // R5
endmodule

bind crk_cracker crk_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .inReady      (inReady),
  .outValid     (outValid),
  .outReady     (outReady),
  .outLaneValid (outLaneValid),
  .outUop       (outUop),
  .seqActive    (seqActive)
);

// File: tb/sim_crk_cracker.sv
`timescale 1ns/1ps
module sim_crk_cracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        inValid;
  logic        inReady;
  logic [2:0]  inCount;
  logic [63:0] inDesc;
  logic        outValid;
  logic        outReady;
  logic [3:0]  outLaneValid;
  logic [55:0] outUop;

  always #2.5 clk = ~clk;

  crk_cracker u0 (.clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inCount(inCount), .inDesc(inDesc), .outValid(outValid), .outReady(outReady),
    .outLaneValid(outLaneValid), .outUop(outUop));

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [13:0] expQ[$];
  string       expTag[$];
  bit          expUc[$];
  string       grpStr = "";
  bit          stallMode = 0;
  logic [7:0]  lfsr = 8'hA5;
  time         tAcc;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input int kind, input logic [2:0] op,
                                     input logic [3:0] dst, input logic [3:0] src, input bit eoi);
    return {kind[1:0], op, dst, src, eoi};
  endfunction

  function automatic logic [15:0] mkDesc(input logic [2:0] op, input logic [1:0] form, input bit cx,
                                         input logic [1:0] rt, input logic [3:0] dst, input logic [3:0] src);
    return {op, form, cx, rt, dst, src};
  endfunction

  task automatic pushExp(input logic [15:0] d);
    logic [2:0] op; logic [1:0] form; logic [1:0] rt; logic [3:0] dst, src;
    op = d[15:13]; form = d[12:11]; rt = d[9:8]; dst = d[7:4]; src = d[3:0];
    if (d[10]) begin
      int len;
      len = 4 + 2 * rt;
      for (int j = 0; j < len; j++) begin
        int kind;
        kind = (j == len - 1) ? 2 : ((j % 2 == 0) ? 1 : 0);
        expQ.push_back(mk(kind, op, dst, (kind == 1) ? src : 4'd15, j == len - 1));
        expTag.push_back("R4,R7"); expUc.push_back(1);
      end
    end else if (form == 2'd1) begin
      expQ.push_back(mk(1, op, 4'd15, src, 0));
      expQ.push_back(mk(0, op, dst, 4'd15, 1));
      repeat (2) begin expTag.push_back("R2,R7"); expUc.push_back(0); end
    end else if (form == 2'd2) begin
      expQ.push_back(mk(1, op, 4'd15, dst, 0));
      expQ.push_back(mk(0, op, 4'd15, src, 0));
      expQ.push_back(mk(2, op, dst, 4'd15, 1));
      repeat (3) begin expTag.push_back("R3,R7"); expUc.push_back(0); end
    end else begin
      expQ.push_back(mk(0, op, dst, src, 1));
      expTag.push_back("R1,R7"); expUc.push_back(0);
    end
  endtask

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic sendGroup(input int cnt, input logic [63:0] desc);
    for (int i = 0; i < cnt; i++) pushExp(desc[16*i +: 16]);
    inValid = 1'b1; inCount = cnt[2:0]; inDesc = desc;
    forever begin
      @(negedge clk);
      if (inReady) begin
        @(posedge clk);
        tAcc = $time;
        break;
      end
    end
    #1;
    inValid = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  // Stall driver: changes outReady only just after a rising edge.
  always begin
    @(posedge clk); #1;
    if (stallMode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      outReady = lfsr[0];
    end else begin
      outReady = 1'b1;
    end
  end

  // Monitor / scoreboard.
  logic [55:0] savedUop;
  logic [3:0]  savedLanes;
  bit          stallPend = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (stallPend) begin
        chk(outValid && outUop == savedUop && outLaneValid == savedLanes, "R9 hold",
            {outValid, outLaneValid, outUop}, {1'b1, savedLanes, savedUop});
        stallPend = 0;
      end
      if (outValid && !outReady) begin
        savedUop = outUop; savedLanes = outLaneValid; stallPend = 1;
      end
      if (outValid && expUc.size() != 0 && expUc[0])
        chk(!inReady, "R8 ready low in microcode", inReady, 0);
      if (outValid && outReady) begin
        int nl;
        nl = 0;
        for (int l = 0; l < 4; l++) begin
          if (outLaneValid[l]) begin
            logic [13:0] got;
            nl++;
            got = outUop[14*l +: 14];
            if (expQ.size() == 0) begin
              chk(0, "R11 unexpected micro-op", got, 0);
            end else begin
              logic [13:0] e;
              string t;
              e = expQ.pop_front(); t = expTag.pop_front(); void'(expUc.pop_front());
              chk(got == e, t, got, e);
            end
          end
        end
        grpStr = {grpStr, $sformatf("%0d,", nl)};
      end
    end
  end

  task automatic chkGroups(input string exp, input string req);
    nChecks++;
    if (grpStr != exp) begin
      nFails++;
      $display("FAIL %s group sizes actual=%s expected=%s", req, grpStr, exp);
    end
    grpStr = "";
  endtask

  task automatic finish();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    time tA;
    rst_n = 1'b0; inValid = 1'b0; inCount = '0; inDesc = '0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!outValid && outLaneValid == 0 && inReady, "R10 in reset", {outValid, outLaneValid, inReady}, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(!outValid && outLaneValid == 0 && inReady, "R10 after reset", {outValid, outLaneValid, inReady}, 1);
    @(posedge clk); #1;

    // R1 R2 R3 R6: mixed short forms, one split instruction
    sendGroup(3, {16'h0, mkDesc(3'd2, 2'd2, 0, 0, 4'd3, 4'd4),
                  mkDesc(3'd1, 2'd1, 0, 0, 4'd5, 4'd6), mkDesc(3'd0, 2'd0, 0, 0, 4'd1, 4'd2)});
    waitDrain();
    chkGroups("4,2,", "R6");

    // R6: four memory-destination forms, groups split instructions
    sendGroup(4, {mkDesc(3'd4, 2'd2, 0, 0, 4'd0, 4'd1), mkDesc(3'd5, 2'd2, 0, 0, 4'd2, 4'd3),
                  mkDesc(3'd6, 2'd2, 0, 0, 4'd4, 4'd5), mkDesc(3'd7, 2'd2, 0, 0, 4'd6, 4'd7)});
    waitDrain();
    chkGroups("4,4,4,", "R6");

    // R5 R4: complex in the middle starts a fresh group; form 3 as R1
    sendGroup(3, {16'h0, mkDesc(3'd3, 2'd3, 0, 0, 4'd7, 4'd0),
                  mkDesc(3'd6, 2'd0, 1, 2'd1, 4'd2, 4'd5), mkDesc(3'd1, 2'd0, 0, 0, 4'd4, 4'd4)});
    waitDrain();
    chkGroups("1,4,2,1,", "R5");

    // R4 R8 R9: longest routine under random stalls
    stallMode = 1;
    sendGroup(1, {48'h0, mkDesc(3'd2, 2'd1, 1, 2'd3, 4'd6, 4'd1)});
    waitDrain();
    chkGroups("4,4,2,", "R5");
    stallMode = 0;
    @(posedge clk); #1;

    // R11: slots past inCount ignored; empty set yields nothing
    sendGroup(2, {mkDesc(3'd7, 2'd2, 1, 2'd3, 4'd1, 4'd1), mkDesc(3'd7, 2'd2, 0, 0, 4'd1, 4'd1),
                  mkDesc(3'd0, 2'd0, 0, 0, 4'd3, 4'd2), mkDesc(3'd1, 2'd1, 0, 0, 4'd0, 4'd7)});
    waitDrain();
    chkGroups("3,", "R11");
    sendGroup(0, {4{mkDesc(3'd5, 2'd2, 0, 0, 4'd1, 4'd2)}});
    repeat (4) begin
      @(negedge clk);
      chk(!outValid && outLaneValid == 0 && inReady, "R11 empty set", {outValid, outLaneValid, inReady}, 1);
    end
    @(posedge clk); #1;

    // R12: back-to-back sets with no bubble
    sendGroup(1, {48'h0, mkDesc(3'd1, 2'd0, 0, 0, 4'd2, 4'd3)});
    tA = tAcc;
    sendGroup(1, {48'h0, mkDesc(3'd2, 2'd0, 0, 0, 4'd4, 4'd5)});
    chk((tAcc - tA) == 5ns, "R12 accept spacing", tAcc - tA, 5ns);
    waitDrain();
    grpStr = "";

    // Random mix under stalls
    stallMode = 1;
    for (int g = 0; g < 30; g++) begin
      logic [63:0] dv;
      int c;
      c = 1 + $urandom_range(0, 3);
      for (int i = 0; i < 4; i++)
        dv[16*i +: 16] = mkDesc($urandom_range(0, 7), $urandom_range(0, 3),
                                ($urandom_range(0, 3) == 0), $urandom_range(0, 3),
                                $urandom_range(0, 7), $urandom_range(0, 7));
      sendGroup(c, dv);
    end
    waitDrain();
    stallMode = 0;
    repeat (3) @(posedge clk);
    finish();
  end
endmodule